// File: doc/BRIEF.md
# I2C Target with Composite Address and Register Pointer

This block is the serial-bus target side of a peripheral controller. It watches the two bus lines through the fast system clock and recognises START and STOP. It shifts address and data bytes and answers each byte with ACK or NACK. It reaches the peripheral's registers through a byte-wide read/write port. The design drives the bus only through open-drain pull-down enables for SDA and SCL.

Its 7-bit bus address is assembled from three sources. The two most significant bits are fixed ones. Four bits come from a programmable input, and the least significant bit comes from a board strap. The block also answers the all-zero broadcast address on writes.

A write transfer first loads an internal register pointer and then writes data bytes at that pointer. A later read transfer returns bytes starting at the stored pointer. While it waits for read data from the register side, the block holds SCL low. Each transfer is limited to eight bytes after the address byte.

Top module: `i2c_tgt_port`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal {1, 1, addr_prog[3], addr_prog[2], addr_prog[1], addr_prog[0], addr_strap}. Bit 0 of the address byte selects the direction: 0 is a write and 1 is a read. An ACK pulls SDA low during the ninth clock.
- R2: An address byte that does not match is answered with NACK (SDA released). Every further byte up to the next START is also NACKed and causes no register access.
- R3: The broadcast address 0000000 with bit 0 = 0 is acknowledged, and so is every following byte within the limit. None of these bytes writes a register. The broadcast address with bit 0 = 1 is NACKed.
- R4: Any START, including one that arrives in the middle of a byte, clears the bit and byte logic, so the next eight bits are taken as an address byte.
- R5: A START followed directly by STOP, with no address byte, causes no register read or write and leaves the target ready for the next transfer.
- R6: In a write transfer, the first byte after the address byte is stored as the register pointer. Each later byte produces one single-cycle reg_we pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte. The pointer then increments.
- R7: At most eight bytes after the address byte are accepted, counting the pointer byte. The ninth byte is NACKed and not written.
- R8: In a read transfer, bytes are returned MSB first, starting at the pointer stored by an earlier write. The pointer increments after each byte, and its value is kept across transfers.
- R9: When the controller NACKs a byte being read, the target releases SDA and makes no further register reads until the next START.
- R10: A read transfer returns at most eight bytes. If the controller ACKs the eighth byte, the target releases SDA, so the controller then reads all ones.
- R11: While a read byte is being fetched (reg_re high), the target holds SCL low. It releases SCL only after reg_rvalid has returned the byte.
- R12: sda_oe changes only while SCL is low.
- R13: During and right after reset, sda_oe, scl_oe, reg_we and reg_re are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level of the SCL bus line |
| sda_i | input | 1 | Level of the SDA bus line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| addr_prog | input | 4 | Programmable address bits 4..1 |
| addr_strap | input | 1 | Strapped address bit 0 |
| reg_addr | output | 8 | Register pointer presented to the register side |
| reg_wdata | output | 8 | Write data byte |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_re | output | 1 | Read request, held until reg_rvalid |
| reg_rdata | input | 8 | Read data byte |
| reg_rvalid | input | 1 | reg_rdata is valid for the pending read |

## Verification
The bench targets four areas: the address bits (each fixed, programmable and strap bit), the broadcast address in both directions, a START landing halfway through a byte, and an empty START/STOP pair. A design that mishandles these would acknowledge a foreign address, write registers on broadcast, or lose bit alignment after a misplaced START. It checks the eight-byte limit on both directions. An off-by-one limit would accept a ninth write or keep driving a ninth read byte instead of returning all ones. Read data is compared against bytes written in earlier transfers, so a pointer that fails to persist or to increment returns the wrong byte. A long read latency checks that SCL is stretched for the whole wait and not released early.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK,
    ST_LOAD,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        last_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], line_i[g]};
        last_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~last_q;
    assign fall_o[g] = ~chain_q[STAGES-1] & last_q;
  end
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match #(
  parameter int PROG_W = 4
) (
  input  logic [7:0]        rx_byte,
  input  logic [PROG_W-1:0] prog_bits,
  input  logic              strap_bit,
  output logic              own_hit,
  output logic              gcall_hit
);
  localparam int FIXED_W = 7 - PROG_W - 1;

  logic [6:0] own_addr;

  assign own_addr  = {{FIXED_W{1'b1}}, prog_bits, strap_bit};
  assign own_hit   = (rx_byte[7:1] == own_addr);
  assign gcall_hit = (rx_byte[7:1] == 7'd0);
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int AW        = 8,
  parameter int MAX_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic          own_hit,
  input  logic          gcall_hit,
  output logic [7:0]    rx_byte,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [7:0]    reg_rdata,
  input  logic          reg_rvalid
);
  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam logic [CW-1:0] CAP = CW'(MAX_BYTES);

  tgt_state_e    state_q, state_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    shr_q, shr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_ok_q, ptr_ok_d;
  logic          gc_q, gc_d;
  logic          rd_q, rd_d;
  logic          mack_q, mack_d;
  logic          sda_q, sda_d;
  logic          we_q, we_d;
  logic [7:0]    wdat_q, wdat_d;
  logic          sclh_q, sclh_d;
  logic          start_ev, stop_ev;

  assign start_ev = sda_fall & scl_lvl;
  assign stop_ev  = sda_rise & scl_lvl;

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    shr_d    = shr_q;
    cnt_d    = cnt_q;
    ptr_d    = ptr_q;
    ptr_ok_d = ptr_ok_q;
    gc_d     = gc_q;
    rd_d     = rd_q;
    mack_d   = mack_q;
    sda_d    = sda_q;
    wdat_d   = wdat_q;
    we_d     = 1'b0;
    if (we_q) ptr_d = ptr_q + 1'b1;

    if (start_ev) begin
      state_d  = ST_ADDR;
      bit_d    = 4'd0;
      cnt_d    = '0;
      ptr_ok_d = 1'b0;
      gc_d     = 1'b0;
      rd_d     = 1'b0;
      sda_d    = 1'b0;
    end else if (stop_ev) begin
      state_d = ST_IDLE;
      sda_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && (bit_q < 4'd8)) begin
            shr_d = {shr_q[6:0], sda_lvl};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && (bit_q == 4'd8)) begin
            if (state_q == ST_ADDR) begin
              if (own_hit || (gcall_hit && !shr_q[0])) begin
                sda_d   = 1'b1;
                rd_d    = shr_q[0];
                gc_d    = gcall_hit;
                state_d = ST_ACK;
              end else begin
                state_d = ST_SKIP;
              end
            end else if (cnt_q == CAP) begin
              state_d = ST_SKIP;
            end else begin
              cnt_d   = cnt_q + 1'b1;
              sda_d   = 1'b1;
              state_d = ST_ACK;
              if (!gc_q) begin
                if (!ptr_ok_q) begin
                  ptr_d    = AW'(shr_q);
                  ptr_ok_d = 1'b1;
                end else begin
                  we_d   = 1'b1;
                  wdat_d = shr_q;
                end
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_d   = 1'b0;
            bit_d   = 4'd0;
            state_d = rd_q ? ST_LOAD : ST_RX;
          end
        end
        ST_LOAD: begin
          if (reg_rvalid) begin
            shr_d   = reg_rdata;
            sda_d   = ~reg_rdata[7];
            ptr_d   = ptr_q + 1'b1;
            cnt_d   = cnt_q + 1'b1;
            bit_d   = 4'd0;
            state_d = ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              sda_d   = 1'b0;
              state_d = ST_MACK;
            end else begin
              shr_d = {shr_q[6:0], 1'b0};
              sda_d = ~shr_q[6];
              bit_d = bit_q + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = sda_lvl;
          end else if (scl_fall) begin
            state_d = (!mack_q && (cnt_q < CAP)) ? ST_LOAD : ST_SKIP;
          end
        end
        default: ;
      endcase
    end

    sclh_d = (state_d == ST_LOAD) || (state_q == ST_LOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_q    <= 4'd0;
      shr_q    <= 8'd0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      ptr_ok_q <= 1'b0;
      gc_q     <= 1'b0;
      rd_q     <= 1'b0;
      mack_q   <= 1'b1;
      sda_q    <= 1'b0;
      we_q     <= 1'b0;
      wdat_q   <= 8'd0;
      sclh_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bit_q    <= bit_d;
      shr_q    <= shr_d;
      cnt_q    <= cnt_d;
      ptr_q    <= ptr_d;
      ptr_ok_q <= ptr_ok_d;
      gc_q     <= gc_d;
      rd_q     <= rd_d;
      mack_q   <= mack_d;
      sda_q    <= sda_d;
      we_q     <= we_d;
      wdat_q   <= wdat_d;
      sclh_q   <= sclh_d;
    end
  end

  assign rx_byte   = shr_q;
  assign sda_oe    = sda_q;
  assign scl_oe    = sclh_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wdat_q;
  assign reg_we    = we_q;
  assign reg_re    = (state_q == ST_LOAD);

  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_q) |-> !$past(scl_lvl)) else $error("sda moved while scl high"); // R12
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state_q == ST_ADDR) && (bit_q == 4'd0)) else $error("start did not rearm"); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we) else $error("write strobe longer than one cycle"); // R6
  AST_BYTE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP) else $error("byte count above cap"); // R7
  AST_STRETCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclh_q) |-> $past(reg_re && reg_rvalid, 2)) else $error("scl released early"); // R11
  AST_NACK_STOPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MACK && scl_fall && mack_q) |=> !reg_re) else $error("read after nack"); // R9
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> (!sda_q && !we_q && !reg_re)) else $error("skip state active"); // R2
endmodule

// File: rtl/i2c_tgt_port.sv
module i2c_tgt_port #(
  parameter int AW        = 8,
  parameter int PROG_W    = 4,
  parameter int MAX_BYTES = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [PROG_W-1:0] addr_prog,
  input  logic              addr_strap,
  output logic [AW-1:0]     reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [7:0]        reg_rdata,
  input  logic              reg_rvalid
);
  logic       rst_meta_q, rst_sync_q;
  logic [1:0] lvl, rise, fall;
  logic [7:0] rx_byte;
  logic       own_hit, gcall_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  i2c_tgt_line_sync #(.LINES(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .line_i ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  i2c_tgt_addr_match #(.PROG_W(PROG_W)) u_match (
    .rx_byte   (rx_byte),
    .prog_bits (addr_prog),
    .strap_bit (addr_strap),
    .own_hit   (own_hit),
    .gcall_hit (gcall_hit)
  );

  i2c_tgt_engine #(.AW(AW), .MAX_BYTES(MAX_BYTES)) u_engine (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .scl_lvl    (lvl[0]),
    .scl_rise   (rise[0]),
    .scl_fall   (fall[0]),
    .sda_lvl    (lvl[1]),
    .sda_rise   (rise[1]),
    .sda_fall   (fall[1]),
    .own_hit    (own_hit),
    .gcall_hit  (gcall_hit),
    .rx_byte    (rx_byte),
    .sda_oe     (sda_oe),
    .scl_oe     (scl_oe),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid)
  );
endmodule

// File: tb/i2c_tgt_port_bench.sv
module i2c_tgt_port_bench;
  localparam int HALF  = 30;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl_low, m_sda_low;
  logic       scl_oe, sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, reg_re, reg_rvalid;
  logic       scl_line, sda_line;
  logic [7:0] mem [256];
  int         lat;
  int         lat_cnt;
  int         we_cnt, re_cnt, stretch_cyc, sda_viol;
  logic [7:0] last_wa, last_wd;
  logic       prev_sda;
  int         n_chk, n_fail;
  logic       done;

  always #2 clk = ~clk;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_tgt_port u_i2c_tgt_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_line),
    .sda_i      (sda_line),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .addr_prog  (4'b1010),
    .addr_strap (1'b1),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid)
  );

  // register side model: mem[a] starts at a ^ 8'hA5
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
      we_cnt <= 0; re_cnt <= 0; stretch_cyc <= 0; sda_viol <= 0;
      lat_cnt <= 0; reg_rvalid <= 1'b0; reg_rdata <= 8'd0;
      last_wa <= 8'd0; last_wd <= 8'd0; prev_sda <= 1'b0;
    end else begin
      prev_sda <= sda_oe;
      if (sda_oe != prev_sda && scl_line) sda_viol <= sda_viol + 1;
      if (scl_oe) stretch_cyc <= stretch_cyc + 1;
      if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        we_cnt  <= we_cnt + 1;
        last_wa <= reg_addr;
        last_wd <= reg_wdata;
      end
      if (reg_rvalid) begin
        reg_rvalid <= 1'b0;
        lat_cnt    <= 0;
      end else if (reg_re) begin
        if (lat_cnt >= lat) begin
          reg_rvalid <= 1'b1;
          reg_rdata  <= mem[reg_addr];
          re_cnt     <= re_cnt + 1;
        end else begin
          lat_cnt <= lat_cnt + 1;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda_low = 1'b0; hw(HALF);
    m_scl_low = 1'b0; wait_high; hw(HALF);
    m_sda_low = 1'b1; hw(HALF);
    m_scl_low = 1'b1; hw(HALF);
  endtask

  task automatic bus_stop;
    m_sda_low = 1'b1; hw(HALF);
    m_scl_low = 1'b0; wait_high; hw(HALF);
    m_sda_low = 1'b0; hw(HALF);
  endtask

  task automatic put_bit(logic b);
    m_sda_low = !b; hw(HALF);
    m_scl_low = 1'b0; wait_high; hw(HALF);
    m_scl_low = 1'b1;
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda_low = 1'b0; hw(HALF);
    m_scl_low = 1'b0; wait_high; hw(HALF / 2);
    ack = !sda_line;
    hw(HALF / 2);
    m_scl_low = 1'b1;
  endtask

  task automatic recv_byte(logic nack, output logic [7:0] b);
    m_sda_low = 1'b0;
    b = 8'd0;
    for (int i = 0; i < 8; i++) begin
      hw(HALF);
      m_scl_low = 1'b0; wait_high; hw(HALF / 2);
      b = {b[6:0], sda_line};
      hw(HALF / 2);
      m_scl_low = 1'b1;
    end
    m_sda_low = !nack; hw(HALF);
    m_scl_low = 1'b0; wait_high; hw(HALF);
    m_scl_low = 1'b1;
    m_sda_low = 1'b0;
  endtask

  // row: [25:18] address byte, [17:10] pointer, [9:2] data, [1] ack expected, [0] write expected
  localparam logic [25:0] ROWS [6] = '{
    {8'hEA, 8'h10, 8'h5A, 1'b1, 1'b1},
    {8'hE8, 8'h11, 8'h33, 1'b0, 1'b0},
    {8'hEE, 8'h12, 8'h44, 1'b0, 1'b0},
    {8'hAA, 8'h13, 8'h55, 1'b0, 1'b0},
    {8'h00, 8'h14, 8'h66, 1'b1, 1'b0},
    {8'hEA, 8'h20, 8'hC3, 1'b1, 1'b1}
  };

  initial begin
    logic       a;
    logic [7:0] b;
    int         w0, r0, s0;
    n_chk = 0; n_fail = 0; done = 1'b0; lat = 3;
    m_scl_low = 1'b0; m_sda_low = 1'b0;
    rst_n = 1'b0;
    hw(10);
    chk("R13 sda_oe in reset", int'(sda_oe), 0);
    chk("R13 scl_oe in reset", int'(scl_oe), 0);
    rst_n = 1'b1;
    hw(10);
    chk("R13 strobes after reset", int'({reg_we, reg_re}), 0);

    for (int r = 0; r < 6; r++) begin
      w0 = we_cnt;
      bus_start;
      send_byte(ROWS[r][25:18], a);
      chk($sformatf("R1 R2 R3 address ack row %0d", r), int'(a), int'(ROWS[r][1]));
      send_byte(ROWS[r][17:10], a);
      chk($sformatf("R2 R3 pointer ack row %0d", r), int'(a), int'(ROWS[r][1]));
      send_byte(ROWS[r][9:2], a);
      chk($sformatf("R2 R3 data ack row %0d", r), int'(a), int'(ROWS[r][1]));
      bus_stop;
      chk($sformatf("R6 R2 R3 write count row %0d", r), we_cnt - w0, int'(ROWS[r][0]));
      if (ROWS[r][0]) begin
        chk($sformatf("R6 write address row %0d", r), int'(last_wa), int'(ROWS[r][17:10]));
        chk($sformatf("R6 write data row %0d", r), int'(last_wd), int'(ROWS[r][9:2]));
      end
    end

    // R3: broadcast address with read direction is refused
    bus_start; send_byte(8'h01, a); bus_stop;
    chk("R3 broadcast read nack", int'(a), 0);

    // R2: after mismatch, a matching byte without START is still ignored
    bus_start; send_byte(8'hE8, a); send_byte(8'hEA, a); bus_stop;
    chk("R2 idle until next START", int'(a), 0);

    // R8 read through pointer, R9 master nack
    bus_start; send_byte(8'hEA, a); send_byte(8'h10, a); bus_stop;
    r0 = re_cnt;
    bus_start; send_byte(8'hEB, a);
    chk("R1 read address ack", int'(a), 1);
    recv_byte(1'b0, b); chk("R8 first read byte", int'(b), 8'h5A);
    recv_byte(1'b1, b); chk("R8 second read byte", int'(b), 8'hB4);
    hw(8);
    chk("R9 sda released after nack", int'(sda_oe), 0);
    bus_stop;
    chk("R9 no read after nack", re_cnt - r0, 2);
    bus_start; send_byte(8'hEB, a); recv_byte(1'b1, b); bus_stop;
    chk("R8 pointer kept across transfers", int'(b), 8'hB7);

    // R7 write cap
    w0 = we_cnt;
    bus_start; send_byte(8'hEA, a); send_byte(8'h40, a);
    for (int k = 1; k <= 8; k++) begin
      send_byte(8'(k), a);
      chk($sformatf("R7 ack of data byte %0d", k), int'(a), (k <= 7) ? 1 : 0);
    end
    bus_stop;
    chk("R7 writes taken", we_cnt - w0, 7);
    chk("R7 last written address", int'(last_wa), 8'h46);

    // R10 read cap
    bus_start; send_byte(8'hEA, a); send_byte(8'h40, a); bus_stop;
    r0 = re_cnt;
    bus_start; send_byte(8'hEB, a);
    for (int k = 0; k < 9; k++) begin
      recv_byte(k == 8, b);
      chk($sformatf("R10 read byte %0d", k), int'(b), (k < 7) ? k + 1 : ((k == 7) ? 8'hE2 : 8'hFF));
    end
    bus_stop;
    chk("R10 register reads", re_cnt - r0, 8);

    // R11 clock stretching with slow register side
    bus_start; send_byte(8'hEA, a); send_byte(8'h20, a); bus_stop;
    lat = 200;
    s0 = stretch_cyc;
    bus_start; send_byte(8'hEB, a); recv_byte(1'b1, b); bus_stop;
    lat = 3;
    chk("R11 stretched read data", int'(b), 8'hC3);
    chk("R11 scl held during fetch", int'((stretch_cyc - s0) >= 200), 1);

    // R5 void message
    w0 = we_cnt; r0 = re_cnt;
    bus_start; bus_stop;
    chk("R5 void no access", (we_cnt - w0) + (re_cnt - r0), 0);
    bus_start; send_byte(8'hEA, a); send_byte(8'h30, a); send_byte(8'h99, a); bus_stop;
    chk("R5 ready after void", int'(last_wd), 8'h99);

    // R4 START in the middle of a byte
    bus_start;
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_start;
    send_byte(8'hEA, a);
    chk("R4 address after misplaced START", int'(a), 1);
    send_byte(8'h50, a); send_byte(8'h77, a); bus_stop;
    chk("R4 write after misplaced START", int'({last_wa, last_wd}), 16'h5077);

    chk("R12 sda changes with scl high", sda_viol, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule